// File: doc/BRIEF.md
# Calibration Retention Table Controller

This block keeps one small table of calibration words for each receive chain of a multi-chain radio. Each table has six entries. Entries 0, 1 and 2 hold the DC-offset values for the loop, low and high settings. Entry 3 holds the filter cutoff value, entry 4 the receive gain settings and entry 5 the peak-detector offset. Software reaches every table through a word-wide register port. Each chain has a data register and a command register. A command with its access bit set starts one read or write of a single entry. The access bit stays at 1 while that operation is in progress and returns to 0 by itself when it completes, so software can poll it.

A global control register holds an enable bit, a six-bit restore mask with one bit per entry index, and a force-restore bit. Setting force-restore while the block is enabled starts a replay pass. The pass visits chains in ascending order and, inside each chain, entries 0 to 5, one position per clock. At each position whose mask bit is set it presents the chain index, the entry index and the 28-bit word on a restore bus with a valid strobe. The force-restore bit reads 1 for the whole pass and then clears itself.

Register map (word addresses): 0 is control, 2c+1 is the data register of chain c, and 2c+2 is the command register of chain c.

Top module: `cal_retain_table`

## Requirements
- R1: After reset, every table entry, data register, command register, the enable bit, the mask and the force-restore bit read 0, and restore valid is low.
- R2: A command with access (bit 0) = 1 and write (bit 1) = 1 stores bits 27:0 of the chain's data register into the entry addressed by command bits 6:4.
- R3: After a command write sets access, the access bit reads 1 for exactly 2 cycles and then reads 0.
- R4: A command with access = 1 and write = 0 loads the addressed entry into bits 27:0 of the chain's data register, readable once access is 0.
- R5: A command written while that chain's access bit is 1 is ignored: its address, write bit and operation have no effect.
- R6: Each chain has its own table, so an operation on one chain leaves the same entry index of every other chain unchanged.
- R7: Data words are 28 bits wide. Bits 31:28 written to a data register are dropped and read back as 0.
- R8: Writing control with enable (bit 0) = 1 and force (bit 1) = 1 makes force read 1 for exactly NCHAIN*6 cycles, after which it reads 0.
- R9: During a pass, restore valid pulses for one cycle for each (chain, entry) whose mask bit (control bits 13:8, bit 8+e for entry e) is 1. The pulses come in ascending chain order and ascending entry order, and each carries that entry's stored word.
- R10: Setting force with enable = 0 produces no restore valid, and force reads 0 from the next cycle.
- R11: An entry address of 6 or 7 is out of range: a write to it changes no entry, and a read from it returns 0.
- R12: Control reads back enable in bit 0, force in bit 1 and the mask in bits 13:8, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| rst_valid | output | 1 | Restore beat strobe |
| rst_chain | output | CW | Chain index of the restore beat |
| rst_entry | output | EW | Entry index of the restore beat |
| rst_data | output | DW | Calibration word of the restore beat |

## Verification
The hardest case to reach from the ports is a second command that lands while a chain's access bit is still 1. The stimulus issues a write command and then, inside the two-cycle window, a read command to another entry. It then checks that the command register still holds the first address and that the data register was not overwritten by the read. For the replay pass, every restore beat is captured on a cycle-by-cycle basis. The captured list is compared in order with a list the bench builds from its own model of the tables and the mask, which exposes both skipped and misordered positions.

// File: rtl/cal_retain_table.sv
`timescale 1ns/1ps
module cal_retain_table #(
  parameter int NCHAIN  = 3,
  parameter int NENTRY  = 6,
  parameter int DW      = 28,
  parameter int ACC_LAT = 2,
  parameter int AW      = $clog2(2*NCHAIN+1),
  parameter int CW      = (NCHAIN > 1) ? $clog2(NCHAIN) : 1,
  parameter int EW      = $clog2(NENTRY)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          rst_valid,
  output logic [CW-1:0] rst_chain,
  output logic [EW-1:0] rst_entry,
  output logic [DW-1:0] rst_data
);
  localparam int MB = 8;
  localparam int AB = 4;
  localparam int LW = (ACC_LAT > 1) ? $clog2(ACC_LAT) : 1;

  logic              en_q, force_q;
  logic [NENTRY-1:0] mask_q;
  logic [CW-1:0]     pch_q;
  logic [EW-1:0]     pen_q;
  logic              ctrl_sel, last_pos;

  logic [NCHAIN-1:0] acc_vec, wrb_vec;
  logic [EW-1:0]     cad_vec [NCHAIN];
  logic [DW-1:0]     dat_vec [NCHAIN];
  logic [DW-1:0]     pick    [NCHAIN];

  logic unused_wd;
  assign unused_wd = ^reg_wdata;

  assign ctrl_sel = reg_wr && (reg_addr == '0);
  assign last_pos = (pch_q == CW'(NCHAIN-1)) && (pen_q == EW'(NENTRY-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      force_q <= 1'b0;
      mask_q  <= '0;
      pch_q   <= '0;
      pen_q   <= '0;
    end else begin
      if (ctrl_sel) begin
        en_q   <= reg_wdata[0];
        mask_q <= reg_wdata[MB +: NENTRY];
      end
      if (force_q) begin
        if (!en_q || last_pos) begin
          force_q <= 1'b0;
          pch_q   <= '0;
          pen_q   <= '0;
        end else if (pen_q == EW'(NENTRY-1)) begin
          pen_q <= '0;
          pch_q <= pch_q + CW'(1);
        end else begin
          pen_q <= pen_q + EW'(1);
        end
      end else if (ctrl_sel && reg_wdata[1]) begin
        force_q <= 1'b1;
      end
    end
  end

  for (genvar c = 0; c < NCHAIN; c++) begin : g_ch
    logic [DW-1:0] tbl [NENTRY];
    logic [DW-1:0] dreg;
    logic          acc_q, wrb_q;
    logic [EW-1:0] cad_q;
    logic [LW-1:0] cnt_q;
    logic          cmd_sel, dat_sel, in_range;

    assign cmd_sel  = reg_wr && (reg_addr == AW'(2*c+2));
    assign dat_sel  = reg_wr && (reg_addr == AW'(2*c+1));
    assign in_range = int'(cad_q) < NENTRY;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int e = 0; e < NENTRY; e++) tbl[e] <= '0;
        dreg  <= '0;
        acc_q <= 1'b0;
        wrb_q <= 1'b0;
        cad_q <= '0;
        cnt_q <= '0;
      end else begin
        if (dat_sel) dreg <= reg_wdata[DW-1:0];
        if (acc_q) begin
          if (cnt_q == LW'(ACC_LAT-1)) begin
            acc_q <= 1'b0;
            if (in_range) begin
              if (wrb_q) tbl[cad_q] <= dreg;
              else       dreg <= tbl[cad_q];
            end else if (!wrb_q) begin
              dreg <= '0;
            end
          end else begin
            cnt_q <= cnt_q + LW'(1);
          end
        end else if (cmd_sel) begin
          acc_q <= reg_wdata[0];
          wrb_q <= reg_wdata[1];
          cad_q <= reg_wdata[AB +: EW];
          cnt_q <= '0;
        end
      end
    end

    assign acc_vec[c] = acc_q;
    assign wrb_vec[c] = wrb_q;
    assign cad_vec[c] = cad_q;
    assign dat_vec[c] = dreg;
    assign pick[c]    = tbl[pen_q];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) begin
      reg_rdata[0]            = en_q;
      reg_rdata[1]            = force_q;
      reg_rdata[MB +: NENTRY] = mask_q;
    end
    for (int c = 0; c < NCHAIN; c++) begin
      if (reg_addr == AW'(2*c+1)) reg_rdata[DW-1:0] = dat_vec[c];
      if (reg_addr == AW'(2*c+2)) begin
        reg_rdata[0]        = acc_vec[c];
        reg_rdata[1]        = wrb_vec[c];
        reg_rdata[AB +: EW] = cad_vec[c];
      end
    end
  end

  assign rst_valid = force_q && en_q && mask_q[pen_q];
  assign rst_chain = pch_q;
  assign rst_entry = pen_q;
  assign rst_data  = pick[pch_q];
endmodule

module cal_retain_chk #(
  parameter int NCHAIN  = 3,
  parameter int NENTRY  = 6,
  parameter int ACC_LAT = 2,
  parameter int CW      = 2,
  parameter int EW      = 3
)(
  input logic              clk,
  input logic              rst_n,
  input logic              force_q,
  input logic              en_q,
  input logic [NCHAIN-1:0] acc_vec,
  input logic              rst_valid,
  input logic [CW-1:0]     rst_chain,
  input logic [EW-1:0]     rst_entry
);
  localparam int TOT = NCHAIN * NENTRY;
  int pos;
  assign pos = int'(rst_chain) * NENTRY + int'(rst_entry);

  if (ACC_LAT == 2) begin : g_lat
    for (genvar c = 0; c < NCHAIN; c++) begin : g_acc
      assert_access_two_cycles_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_vec[c]) |=> acc_vec[c] ##1 !acc_vec[c]);
    end
  end

  assert_force_without_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_q) && !en_q |=> !force_q);

  assert_restore_walk_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_q && $past(force_q) && en_q && $past(en_q) |-> pos == $past(pos) + 1);

  assert_pass_ends_at_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_q) && $past(en_q) |-> $past(pos) == TOT - 1);

  assert_beat_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_valid |-> (int'(rst_entry) < NENTRY) && (int'(rst_chain) < NCHAIN));
endmodule

bind cal_retain_table cal_retain_chk #(
  .NCHAIN(NCHAIN), .NENTRY(NENTRY), .ACC_LAT(ACC_LAT), .CW(CW), .EW(EW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .force_q(force_q), .en_q(en_q), .acc_vec(acc_vec),
  .rst_valid(rst_valid), .rst_chain(rst_chain), .rst_entry(rst_entry)
);

// File: tb/cal_retain_table_tb.sv
`timescale 1ns/1ps
module cal_retain_table_tb;
  localparam int NCH = 3;
  localparam int NEN = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rst_valid;
  logic [1:0]  rst_chain;
  logic [2:0]  rst_entry;
  logic [27:0] rst_data;

  int errors = 0;
  int checks = 0;
  logic [27:0] model [NCH][NEN];

  always #5 clk = ~clk;

  cal_retain_table u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_valid(rst_valid),
    .rst_chain(rst_chain), .rst_entry(rst_entry), .rst_data(rst_data)
  );

  // {chain, entry, data}
  localparam logic [36:0] VEC [10] = '{
    {2'd0, 3'd4, 32'h0AAA_0004}, {2'd0, 3'd5, 32'h0BBB_0005},
    {2'd1, 3'd4, 32'h0CCC_1004}, {2'd1, 3'd5, 32'hF123_4567},
    {2'd2, 3'd4, 32'h0DDD_2004}, {2'd2, 3'd5, 32'h0EEE_2005},
    {2'd0, 3'd0, 32'h0000_0101}, {2'd1, 3'd3, 32'h0777_7313},
    {2'd2, 3'd1, 32'hA000_0021}, {2'd2, 3'd5, 32'h0555_5525}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic tbl_write(input int c, input int e, input logic [31:0] d);
    reg_write(3'(2*c+1), d);
    reg_write(3'(2*c+2), 32'((e << 4) | 3));
    repeat (2) @(negedge clk);
  endtask

  task automatic tbl_read(input int c, input int e, output logic [31:0] d);
    reg_write(3'(2*c+2), 32'((e << 4) | 1));
    repeat (2) @(negedge clk);
    reg_read(3'(2*c+1), d);
  endtask

  task automatic run_pass(input logic [5:0] m);
    logic [31:0] v;
    int nb;
    logic [36:0] got [18];
    logic [36:0] exp [18];
    int ne;
    ne = 0;
    for (int c = 0; c < NCH; c++)
      for (int e = 0; e < NEN; e++)
        if (m[e]) begin exp[ne] = {2'(c), 3'(e), 4'h0, model[c][e]}; ne++; end
    nb = 0;
    reg_write(3'd0, {18'd0, m, 8'h03});
    for (int k = 0; k < NCH*NEN; k++) begin
      reg_read(3'd0, v);
      check(v[1] == 1'b1, "R8 force busy during pass", v, {18'd0, m, 8'h03});
      if (rst_valid) begin
        if (nb < 18) got[nb] = {rst_chain, rst_entry, 4'h0, rst_data};
        nb++;
      end
      @(negedge clk);
    end
    reg_read(3'd0, v);
    check(v[1] == 1'b0, "R8 force clears after pass", v, {18'd0, m, 8'h01});
    check(nb == ne, "R9 restore beat count", 32'(nb), 32'(ne));
    for (int i = 0; i < ne && i < nb; i++)
      check(got[i] == exp[i], "R9 restore beat content/order", got[i][31:0] ^ 32'(got[i][36:32]) << 28, exp[i][31:0] ^ 32'(exp[i][36:32]) << 28);
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < NCH; c++) for (int e = 0; e < NEN; e++) model[c][e] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(3'd0, v); check(v == 0, "R1 control after reset", v, 0);
    reg_read(3'd1, v); check(v == 0, "R1 data after reset", v, 0);
    reg_read(3'd6, v); check(v == 0, "R1 command after reset", v, 0);
    check(rst_valid == 1'b0, "R1 restore valid low", 32'(rst_valid), 0);
    tbl_read(1, 4, v); check(v == 0, "R1 entry cleared", v, 0);

    // vector table: writes then read-back (R2, R4, R7)
    for (int i = 0; i < 10; i++) begin
      tbl_write(int'(VEC[i][36:35]), int'(VEC[i][34:32]), VEC[i][31:0]);
      model[VEC[i][36:35]][VEC[i][34:32]] = VEC[i][27:0];
    end
    for (int i = 0; i < 10; i++) begin
      tbl_read(int'(VEC[i][36:35]), int'(VEC[i][34:32]), v);
      check(v == {4'h0, model[VEC[i][36:35]][VEC[i][34:32]]}, "R2 R4 R7 entry read-back", v,
            {4'h0, model[VEC[i][36:35]][VEC[i][34:32]]});
    end

    // R12 control fields
    reg_write(3'd0, 32'h0000_1001);
    reg_read(3'd0, v); check(v == 32'h0000_1001, "R12 control readback", v, 32'h0000_1001);

    // R3 access timing
    reg_write(3'd3, 32'h0123_4560);
    reg_write(3'd4, 32'h0000_0023);
    reg_read(3'd4, v); check(v[0] == 1'b1, "R3 access cycle 1", v, 32'h23);
    @(negedge clk);
    reg_read(3'd4, v); check(v[0] == 1'b1, "R3 access cycle 2", v, 32'h23);
    @(negedge clk);
    reg_read(3'd4, v); check(v == 32'h0000_0022, "R3 access cleared", v, 32'h22);
    model[1][2] = 28'h123_4560;

    // R5 command during busy ignored
    reg_write(3'd1, 32'h0FED_CBA9);
    reg_write(3'd2, 32'h0000_0013);
    reg_write(3'd2, 32'h0000_0021);
    repeat (2) @(negedge clk);
    model[0][1] = 28'hFED_CBA9;
    reg_read(3'd2, v); check(v == 32'h0000_0012, "R5 command fields kept", v, 32'h12);
    reg_read(3'd1, v); check(v == 32'h0FED_CBA9, "R5 read not performed", v, 32'h0FED_CBA9);
    tbl_read(0, 1, v); check(v == 32'h0FED_CBA9, "R5 first write stored", v, 32'h0FED_CBA9);

    // R6 chain independence
    tbl_write(1, 0, 32'h0999_9999);
    model[1][0] = 28'h999_9999;
    tbl_read(0, 0, v); check(v == {4'h0, model[0][0]}, "R6 other chain untouched", v, {4'h0, model[0][0]});
    tbl_read(2, 0, v); check(v == 0, "R6 third chain untouched", v, 0);

    // R11 out of range address
    tbl_write(2, 6, 32'h0ABC_DEF0);
    tbl_read(2, 6, v); check(v == 0, "R11 out-of-range read", v, 0);
    for (int e = 0; e < NEN; e++) begin
      tbl_read(2, e, v); check(v == {4'h0, model[2][e]}, "R11 no entry changed", v, {4'h0, model[2][e]});
    end

    // R10 force with enable off
    reg_write(3'd0, 32'h0000_3F02);
    reg_read(3'd0, v); check(v[1] == 1'b1, "R10 force set one cycle", v, 32'h3F02);
    check(rst_valid == 1'b0, "R10 no valid", 32'(rst_valid), 0);
    @(negedge clk);
    reg_read(3'd0, v); check(v == 32'h0000_3F00, "R10 force cleared", v, 32'h3F00);
    check(rst_valid == 1'b0, "R10 no valid later", 32'(rst_valid), 0);

    // R8 R9 restore passes
    run_pass(6'h30);
    run_pass(6'h10);
    run_pass(6'h3F);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule